// File: doc/BRIEF.md
# Paged Serial Configuration Readout Sequencer

This block is the read-side controller of a serial configuration memory. It holds an address counter and a bit counter. On each DCLK strobe it shifts one bit of the stored bitstream out to a programmable device, most significant bit first. Each address holds one 16-bit word. The memory array sits behind a synchronous word-read port. The block presents the address of the next cycle, and the array returns that word one clock later.

A combined reset/output-enable input (`rst_oe`) controls the sequencer:
- While `rst_oe` is low, both counters are cleared and the page choice is sampled.
- While `rst_oe` is high, an active-low select (`cs_n`) gates counting and the output driver.

An optional page mode splits the address space into four equal partitions, and the page select sets both the start and the end address. A cascade output goes low once the last address of the active range has been reached. This lets the next device in a daisy chain take over. When serial mode is off, the sequencer freezes and stays quiet.

Top module: `cfg_stream_seq`

## Requirements
- R1: `sdo_en` is 1 exactly when `ser_mode`=1, `cs_n`=0 and `rst_oe`=1. Whenever `sdo_en` is 0, `sdo` is 0.
- R2: While `ser_mode`=1 and `rst_oe`=0, the bit counter is 0 and the address counter holds the partition base. With `part_en`=1 the base is `part_sel` placed in the top two address bits and zero below. With `part_en`=0 the base is 0. `mem_addr` shows the address counter whenever no strobe is applied.
- R3: The page choice (`part_en`, `part_sel`) is captured while `rst_oe` is low. Changes to it while `rst_oe` is high affect neither the address nor the end of the range.
- R4: `mem_addr` carries the address counter's next value. `mem_data` is the word at the current address. `sdo` is bit (WORD_W-1-bit counter) of that word, so the word goes out MSB first. Each `dclk_tick` while enabled advances the bit counter. After the last bit, the counter wraps to 0 and the address increments.
- R5: With `cs_n`=1, or with `dclk_tick`=0, neither counter moves.
- R6: With `part_en`=0, `part_sel` is ignored and the range runs from 0 to the all-ones address.
- R7: The address saturates at the top of the active range. Further strobes keep cycling the bits of the last word.
- R8: One clock after the address counter reaches the top of the range, `casc_n` goes low. It stays low while `cs_n`=0 and `rst_oe`=1.
- R9: After the end has been reached, with `rst_oe` held high, `casc_n` follows `cs_n`.
- R10: A low `rst_oe` clears the end state. `casc_n` then stays 1 until the range has been read to its top again.
- R11: With `ser_mode`=0, the outputs are `sdo_en`=0 and `casc_n`=1. The strobe, `cs_n`, `rst_oe` and the page inputs change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ser_mode | input | 1 | 1 = serial readout mode, 0 = frozen (programming) |
| cs_n | input | 1 | Active-low select |
| rst_oe | input | 1 | Low: clear counters; high: enable output |
| part_en | input | 1 | 1 = four-partition page mode |
| part_sel | input | 2 | Partition number in page mode |
| dclk_tick | input | 1 | One-cycle strobe per serial clock edge |
| mem_addr | output | ADDR_W | Word address presented to the array |
| mem_data | input | WORD_W | Word returned one clock after `mem_addr` |
| sdo | output | 1 | Serial data bit |
| sdo_en | output | 1 | Output driver enable (tri-state control) |
| casc_n | output | 1 | Active-low cascade, end of range reached |

## Verification
The bench targets the following corner cases, each with the failure it exposes:
- **Page change after release of `rst_oe`.** A design that keeps tracking the page inputs would jump or end early.
- **Word boundary.** An off-by-one there would repeat or skip a bit, or read the wrong word for a cycle.
- **End of partition.** A counter that wraps instead of saturating would restart the stream and release `casc_n`.
- **Order of deselect and output-enable drop.** Toggling `cs_n` before dropping `rst_oe` must make `casc_n` follow `cs_n`. Dropping `rst_oe` must leave `casc_n` high, and a design that keeps the end state would pull it low again.
- **Serial mode off.** The bench exercises every input in this mode. A leaky design would move its counters or drive its output.

// File: rtl/cfgseq_pkg.sv
package cfgseq_pkg;

    // Captured page choice
    typedef struct packed {
        logic       en;
        logic [1:0] sel;
    } page_t;

endpackage

// File: rtl/cfgseq_page.sv
module cfgseq_page
    import cfgseq_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              part_en,
    input  logic [1:0]        part_sel,
    output logic [ADDR_W-1:0] live_base,
    output logic [ADDR_W-1:0] top_addr
);
    localparam int QW = ADDR_W - 2;

    page_t page_d, page_q;

    always_comb begin
        page_d = page_q;
        if (load) begin
            page_d.en  = part_en;
            page_d.sel = part_sel;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) page_q <= '0;
        else        page_q <= page_d;
    end

    // base follows live inputs (counter loads it during reset); end uses latched choice
    assign live_base = part_en ? {part_sel, {QW{1'b0}}} : '0;
    assign top_addr  = page_q.en ? {page_q.sel, {QW{1'b1}}} : '1;

    a_r3_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(top_addr));

endmodule

// File: rtl/cfgseq_count.sv
module cfgseq_count #(
    parameter int ADDR_W = 20,
    parameter int WORD_W = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       ser_mode,
    input  logic                       cs_n,
    input  logic                       rst_oe,
    input  logic                       tick,
    input  logic [ADDR_W-1:0]          live_base,
    input  logic [ADDR_W-1:0]          top_addr,
    output logic [ADDR_W-1:0]          addr_nxt,
    output logic [$clog2(WORD_W)-1:0]  bit_idx,
    output logic                       at_top
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(WORD_W - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [BIT_W-1:0]  bits;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (ser_mode) begin
            if (!rst_oe) begin
                cnt_d.addr = live_base;
                cnt_d.bits = '0;
            end else if (!cs_n && tick) begin
                if (cnt_q.bits == LAST) begin
                    cnt_d.bits = '0;
                    if (cnt_q.addr != top_addr)
                        cnt_d.addr = cnt_q.addr + 1'b1;
                end else begin
                    cnt_d.bits = cnt_q.bits + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign addr_nxt = cnt_d.addr;
    assign bit_idx  = LAST - cnt_q.bits;
    assign at_top   = (cnt_q.addr == top_addr);

    a_r2_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && !rst_oe) |=> (bit_idx == LAST));
    a_r5_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && rst_oe && (cs_n || !tick)) |=> ($stable(addr_nxt) || !rst_oe || !ser_mode || tick));
    a_r7_saturate: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && rst_oe && at_top) |=> (at_top || !rst_oe || !ser_mode));
    a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!ser_mode) |=> $stable(bit_idx));

endmodule

// File: rtl/cfgseq_casc.sv
module cfgseq_casc (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_mode,
    input  logic cs_n,
    input  logic rst_oe,
    input  logic at_top,
    output logic casc_n
);
    typedef struct packed {
        logic done;
    } casc_t;

    casc_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ser_mode) begin
            if (!rst_oe)     st_d.done = 1'b0;
            else if (at_top) st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign casc_n = !(st_q.done && ser_mode && rst_oe && !cs_n);

    a_r8_end_low: assert property (@(posedge clk) disable iff (!rst_n)
        (at_top && ser_mode && rst_oe) ##1 (ser_mode && rst_oe && !cs_n) |-> !casc_n);
    a_r10_oe_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode && !rst_oe) ##1 !at_top |-> casc_n);

endmodule

// File: rtl/cfg_stream_seq.sv
module cfg_stream_seq #(
    parameter int ADDR_W = 20,
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_mode,
    input  logic              cs_n,
    input  logic              rst_oe,
    input  logic              part_en,
    input  logic [1:0]        part_sel,
    input  logic              dclk_tick,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [WORD_W-1:0] mem_data,
    output logic              sdo,
    output logic              sdo_en,
    output logic              casc_n
);
    localparam int BIT_W = $clog2(WORD_W);

    logic [ADDR_W-1:0] live_base, top_addr;
    logic [BIT_W-1:0]  bit_idx;
    logic              at_top;

    cfgseq_page #(.ADDR_W(ADDR_W)) page_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ser_mode && !rst_oe),
        .part_en   (part_en),
        .part_sel  (part_sel),
        .live_base (live_base),
        .top_addr  (top_addr)
    );

    cfgseq_count #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) count_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ser_mode  (ser_mode),
        .cs_n      (cs_n),
        .rst_oe    (rst_oe),
        .tick      (dclk_tick),
        .live_base (live_base),
        .top_addr  (top_addr),
        .addr_nxt  (mem_addr),
        .bit_idx   (bit_idx),
        .at_top    (at_top)
    );

    cfgseq_casc casc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ser_mode (ser_mode),
        .cs_n     (cs_n),
        .rst_oe   (rst_oe),
        .at_top   (at_top),
        .casc_n   (casc_n)
    );

    assign sdo_en = ser_mode && !cs_n && rst_oe;
    assign sdo    = sdo_en && mem_data[bit_idx];

    a_r1_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |-> !sdo);
    a_r11_no_cascade: assert property (@(posedge clk) disable iff (!rst_n)
        !ser_mode |-> (casc_n && !sdo_en));

endmodule

// File: tb/cfg_stream_seq_tb_top.sv
module cfg_stream_seq_tb_top;
    localparam int AW = 8;
    localparam int WW = 16;

    logic clk = 0, rst_n = 0;
    logic ser_mode = 1, cs_n = 1, rst_oe = 0, part_en = 0, dclk_tick = 0;
    logic [1:0] part_sel = 0;
    logic [AW-1:0] mem_addr;
    logic [WW-1:0] mem_data = '0;
    logic sdo, sdo_en, casc_n;

    int checks = 0, errors = 0;
    int m_addr = 0, m_bit = 0, m_pen = 0, m_psel = 0, m_done = 0;

    always #4 clk = ~clk;

    cfg_stream_seq #(.ADDR_W(AW), .WORD_W(WW)) dut_i (
        .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .cs_n(cs_n),
        .rst_oe(rst_oe), .part_en(part_en), .part_sel(part_sel),
        .dclk_tick(dclk_tick), .mem_addr(mem_addr), .mem_data(mem_data),
        .sdo(sdo), .sdo_en(sdo_en), .casc_n(casc_n)
    );

    function automatic logic [15:0] word_of(int a);
        return 16'((a * 40503 + 23130) ^ (a << 7));
    endfunction

    always @(posedge clk) mem_data <= word_of(int'(mem_addr));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_addr = 0; m_bit = 0; m_pen = 0; m_psel = 0; m_done = 0;
        end else if (ser_mode) begin
            if (!rst_oe) begin
                m_pen = part_en; m_psel = part_sel;
                m_addr = part_en ? part_sel * 64 : 0;
                m_bit = 0; m_done = 0;
            end else begin
                int top;
                top = m_pen ? m_psel * 64 + 63 : 255;
                if (m_addr == top) m_done = 1;
                if (!cs_n && dclk_tick) begin
                    if (m_bit == 15) begin
                        m_bit = 0;
                        if (m_addr != top) m_addr++;
                    end else m_bit++;
                end
            end
        end
    end

    always @(negedge clk) if (rst_n) begin
        logic exp_en, exp_sdo, exp_casc;
        logic [15:0] w;
        w = word_of(m_addr);
        exp_en = ser_mode && !cs_n && rst_oe;
        exp_sdo = exp_en && w[15 - m_bit];
        exp_casc = !(m_done && exp_en);
        check(sdo_en == exp_en, "R1 sdo_en", sdo_en, exp_en);
        check(sdo == exp_sdo, "R4 sdo", sdo, exp_sdo);
        check(casc_n == exp_casc, "R8 casc_n", casc_n, exp_casc);
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic run(input int n, input int patt);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            dclk_tick = (patt == 0) ? 1'b1 : (i % 3 != 0);
        end
        @(posedge clk); #1; dclk_tick = 0;
        #2;
    endtask

    initial begin
        #200000;
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        part_en = 1; part_sel = 2;
        step(3); rst_n = 1; step(3); #2;
        check(mem_addr == 8'h80, "R2 base page 2", mem_addr, 8'h80);
        check(casc_n == 1 && sdo_en == 0, "R1 reset outputs", {casc_n, sdo_en}, 2'b10);
        // release, then change page: must be ignored
        step(1); rst_oe = 1; part_sel = 0; step(2); #2;
        check(mem_addr == 8'h80, "R3 page held", mem_addr, 8'h80);
        cs_n = 0;
        run(40, 0);
        check(mem_addr == 8'h82, "R4 word advance", mem_addr, 8'h82);
        // deselected strobes
        cs_n = 1; run(20, 0);
        check(mem_addr == 8'h82, "R5 cs_n high hold", mem_addr, 8'h82);
        cs_n = 0; run(30, 1);
        // run past end of partition 2
        run(1100, 0);
        check(mem_addr == 8'hBF, "R7 saturate at top", mem_addr, 8'hBF);
        check(casc_n == 0, "R8 casc low at end", casc_n, 0);
        // deselect first: cascade follows cs_n
        step(1); cs_n = 1; #2;
        check(casc_n == 1, "R9 follows cs_n high", casc_n, 1);
        step(1); cs_n = 0; #2;
        check(casc_n == 0, "R9 follows cs_n low", casc_n, 0);
        // drop OE: end state cleared, new page (sel 0) captured
        step(1); rst_oe = 0; step(2); rst_oe = 1; #2;
        check(casc_n == 1, "R10 cleared after OE low", casc_n, 1);
        check(mem_addr == 8'h00, "R3 recaptured page 0", mem_addr, 8'h00);
        run(50, 0);
        check(casc_n == 1, "R10 stays high mid-range", casc_n, 1);
        // serial mode off: nothing moves
        step(1); ser_mode = 0; #2;
        begin
            logic [AW-1:0] held;
            held = mem_addr;
            run(40, 0);
            step(1); rst_oe = 0; part_sel = 3; step(3); rst_oe = 1; #2;
            check(mem_addr == held, "R11 addr frozen", mem_addr, held);
            check(sdo_en == 0 && casc_n == 1, "R11 outputs quiet", {sdo_en, casc_n}, 2'b01);
        end
        step(1); ser_mode = 1;
        // full range, page mode off, sel ignored
        step(1); rst_oe = 0; part_en = 0; part_sel = 3; step(2); #2;
        check(mem_addr == 8'h00, "R6 base 0 when page off", mem_addr, 8'h00);
        step(1); rst_oe = 1; run(16 * 64 + 5, 0);
        check(mem_addr == 8'h40 && casc_n == 1, "R6 crosses quarter", {mem_addr, casc_n}, 9'h81);
        run(4096, 0);
        check(mem_addr == 8'hFF, "R6 top is all ones", mem_addr, 8'hFF);
        check(casc_n == 0, "R8 casc at full end", casc_n, 0);
        step(2);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule